// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer whose 6-bit down counter is decremented by a prescaled tick taken from the watchdog clock. Software proves it is alive by writing a fixed key word to a refresh register. The refresh is honoured only while the counter has already fallen to, or below, a programmable window limit. A refresh that arrives too early, or a counter that runs out, raises a one-cycle system reset request and latches a sticky reset-occurred flag.

The block has a single-cycle register strobe interface with four word registers: a write-only refresh key (word 0), control (word 1), status (word 2) and a read-only live count (word 3). When the counter reaches the window limit it sets a match flag, which can drive an interrupt line. A debug-halt input can freeze counting unless control bit 31 says to ignore it. The bus and the watchdog logic share one clock.

Top module: `wdog_window_top`

## Requirements
- R1: After reset the count reads 0x3F, control and status read 0, and irq and wdt_rst are low.
- R2: While enabled and not held, the count falls by one every N clocks. N is chosen by control bits 11:8: codes 0..15 give 1, 2, 4, 8, 16, 32, 64, 128, 192, 256, 384, 512, 768, 1024, 1536 and 2048. Each control write restarts the prescaler, so the first decrement comes N clocks after that write.
- R3: With control bit 0 (enable) clear, the count does not change except by a refresh.
- R4: Writing 0x00005AA5 to word 0 while count <= window limit (control bits 21:16) reloads the count to 0x3F with no reset request.
- R5: Any other value written to word 0 has no effect on the count, the status or wdt_rst.
- R6: Writing the key while count > window limit drives wdt_rst high for exactly the next cycle, sets status bit 1 and reloads the count to 0x3F.
- R7: When a prescaled tick arrives with the count at 0, wdt_rst pulses for one cycle, status bit 1 is set and the count reloads to 0x3F. From 0x3F at ratio 1 the pulse appears 64 clocks after the enabling control write.
- R8: A decrement that lands on the window limit sets status bit 0. irq equals status bit 0 AND control bit 1.
- R9: Writing 1 to status bit 0 or bit 1 clears that bit. When a set and a clear of bit 0 fall in the same cycle, the set wins.
- R10: With control bit 31 clear and dbg_halt high, the count holds. With bit 31 set, it keeps counting.
- R11: Reads return data one cycle after the read strobe. Control reads back bit 0, bit 1, bits 11:8, bits 21:16 and bit 31, with other bits 0. Word 3 returns the count in bits 5:0.
- R12: A valid refresh in the same cycle as a tick that would time out wins: the count reloads and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Window-match interrupt |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
Two functions can act on the counter in the same cycle: a key write and a prescaled tick that finds the counter at zero. The bench enables ratio 1 from a count of 0x3F, waits 63 cycles, and places the key write on the 64th edge, where the timeout would fall. It then judges that wdt_rst stays low, the count reads 0x3F and the reset flag stays clear. A second collision puts a write-1-to-clear of the match flag on the edge where the count lands on the window limit, and expects the flag to read back as set.

// File: rtl/wwin_pkg.sv
package wwin_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 6;
  localparam int SEL_W   = 4;
  localparam int RATIO_W = 12;
  localparam int ADDR_W  = 4;
  localparam int IDX_LSB = 2;

  localparam logic [1:0] IDX_KEY = 2'd0;
  localparam logic [1:0] IDX_CTL = 2'd1;
  localparam logic [1:0] IDX_STS = 2'd2;
  localparam logic [1:0] IDX_CNT = 2'd3;

  localparam logic [DATA_W-1:0] KEY_VAL = 32'h0000_5AA5;

  // control field positions (software decodes these)
  localparam int B_RUN   = 0;
  localparam int B_IEN   = 1;
  localparam int SEL_LSB = 8;
  localparam int CMP_LSB = 16;
  localparam int B_IGN   = 31;
  // status field positions
  localparam int B_MATCH = 0;
  localparam int B_RSTF  = 1;

  typedef struct packed {
    logic             ign_halt;
    logic [CNT_W-1:0] win;
    logic [SEL_W-1:0] sel;
    logic             ien;
    logic             run;
  } ctl_t;

  // divide ratio: powers of two for codes 0..7, then alternating 3*2^k and 4*2^k
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
    logic [RATIO_W-1:0] one;
    one = 1;
    if (!sel[3])     return one << sel[2:0];
    else if (!sel[0]) return 12'd192 << sel[2:1];
    else              return 12'd256 << sel[2:1];
  endfunction
endpackage

// File: rtl/wwin_prescaler.sv
module wwin_prescaler
  import wwin_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          hold,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [RW-1:0] psc_q;
  logic [RW-1:0] ratio;

  assign ratio = RW'(div_ratio(SEL_W'(sel)));
  assign tick  = !restart && !hold && (psc_q == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart)  psc_q <= '0;
    else if (!hold)      psc_q <= tick ? '0 : psc_q + 1'b1;
  end

  // R2: the prescaler never runs past the selected ratio
  a_r2_psc_in_range: assert property (@(posedge clk) disable iff (rst)
    psc_q < ratio);
endmodule

// File: rtl/wwin_downcnt.sv
module wwin_downcnt
  import wwin_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          key_wr,
  input  logic [CW-1:0] win,
  output logic [CW-1:0] cnt,
  output logic          bad_refresh,
  output logic          timeout,
  output logic          hit
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dec;

  assign dec         = cnt_q - 1'b1;
  assign bad_refresh = key_wr && (cnt_q > win);
  assign timeout     = tick && !key_wr && (cnt_q == '0);
  assign hit         = tick && !key_wr && (cnt_q != '0) && (dec == win);
  assign cnt         = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= TOP;
    else if (key_wr)            cnt_q <= TOP;
    else if (tick) begin
      if (cnt_q == '0)          cnt_q <= TOP;
      else                      cnt_q <= dec;
    end
  end

  // R4: an in-window refresh reloads the counter
  a_r4_refresh_reload: assert property (@(posedge clk) disable iff (rst)
    (key_wr && cnt_q <= win) |=> (cnt_q == TOP));
  // R7: a tick at zero wraps to the top value
  a_r7_timeout_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && !key_wr && cnt_q == '0) |=> (cnt_q == TOP));
  // R12: key and timeout tick together never leave the count at zero
  a_r12_key_wins: assert property (@(posedge clk) disable iff (rst)
    (tick && key_wr && cnt_q == '0) |=> (cnt_q == TOP));
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dbg_halt,
  output logic          irq,
  output logic          wdt_rst
);
  logic [1:0]    idx;
  logic          ctl_wr, sts_wr, key_wr;
  logic          run_q, ien_q, ign_q;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] win_q;
  logic          match_q, rstf_q, pulse_q;
  logic [DW-1:0] rdata_q;
  logic          count_ok, tick;
  logic [CW-1:0] cnt;
  logic          bad_refresh, timeout, hit, rst_evt;

  assign idx    = bus_addr[IDX_LSB +: 2];
  assign ctl_wr = bus_wr && (idx == IDX_CTL);
  assign sts_wr = bus_wr && (idx == IDX_STS);
  assign key_wr = bus_wr && (idx == IDX_KEY) && (bus_wdata == KEY_VAL);

  assign count_ok = run_q && (ign_q || !dbg_halt);
  assign rst_evt  = bad_refresh || timeout;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DW-2:CMP_LSB+CW], bus_wdata[CMP_LSB-1:SEL_LSB+SW],
                          bus_wdata[SEL_LSB-1:B_IEN+1], bus_addr[IDX_LSB-1:0]};

  wwin_prescaler #(.SW(SW), .RW(RATIO_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .restart (ctl_wr || !run_q),
    .hold    (!count_ok),
    .sel     (sel_q),
    .tick    (tick)
  );

  wwin_downcnt #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .key_wr      (key_wr),
    .win         (win_q),
    .cnt         (cnt),
    .bad_refresh (bad_refresh),
    .timeout     (timeout),
    .hit         (hit)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      ign_q <= 1'b0;
      sel_q <= '0;
      win_q <= '0;
    end else if (ctl_wr) begin
      run_q <= bus_wdata[B_RUN];
      ien_q <= bus_wdata[B_IEN];
      ign_q <= bus_wdata[B_IGN];
      sel_q <= bus_wdata[SEL_LSB +: SW];
      win_q <= bus_wdata[CMP_LSB +: CW];
    end
  end

  // status flags: a set event takes priority over a write-1 clear
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      rstf_q  <= 1'b0;
    end else begin
      if (hit)                              match_q <= 1'b1;
      else if (sts_wr && bus_wdata[B_MATCH]) match_q <= 1'b0;
      if (rst_evt)                          rstf_q  <= 1'b1;
      else if (sts_wr && bus_wdata[B_RSTF])  rstf_q  <= 1'b0;
    end
  end

  // reset request pulse, never longer than one cycle
  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= rst_evt && !pulse_q;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      rdata_q <= '0;
      case (idx)
        IDX_CTL: begin
          rdata_q[B_RUN]            <= run_q;
          rdata_q[B_IEN]            <= ien_q;
          rdata_q[SEL_LSB +: SW]    <= sel_q;
          rdata_q[CMP_LSB +: CW]    <= win_q;
          rdata_q[B_IGN]            <= ign_q;
        end
        IDX_STS: begin
          rdata_q[B_MATCH] <= match_q;
          rdata_q[B_RSTF]  <= rstf_q;
        end
        IDX_CNT: rdata_q[CW-1:0] <= cnt;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign wdt_rst   = pulse_q;
  assign irq       = match_q && ien_q;

  // R3: a stopped counter changes only through the key
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !key_wr) |=> $stable(cnt));
  // R10: debug halt freezes the count unless told to ignore it
  a_r10_debug_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && dbg_halt && !ign_q && !key_wr) |=> $stable(cnt));
  // R6: early refresh yields a reset request and the sticky flag
  a_r6_early_key: assert property (@(posedge clk) disable iff (rst)
    (bad_refresh && !pulse_q) |=> (wdt_rst && rstf_q));
  // R6/R7: reset request is a single-cycle pulse
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> !wdt_rst);
  // R9: the flag is set whenever a reset request is out
  a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |-> rstf_q);
  // R8: a window hit always shows up in the flag
  a_r8_hit_sets: assert property (@(posedge clk) disable iff (rst)
    hit |=> match_q);
endmodule

// File: tb/wdog_window_top_test.sv
module wdog_window_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq, wdt_rst;

  int total = 0;
  int bad   = 0;
  logic [31:0] v;

  always #10 clk = ~clk; // 50 MHz

  wdog_window_top uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  // {code[31:28], wait[27:8], 2'b0, expected count[5:0]}
  localparam logic [31:0] VEC [12] = '{
    {4'd0,  20'd10,   2'b0, 6'h35},
    {4'd1,  20'd11,   2'b0, 6'h3A},
    {4'd2,  20'd9,    2'b0, 6'h3D},
    {4'd3,  20'd17,   2'b0, 6'h3D},
    {4'd7,  20'd300,  2'b0, 6'h3D},
    {4'd8,  20'd400,  2'b0, 6'h3D},
    {4'd9,  20'd600,  2'b0, 6'h3D},
    {4'd10, 20'd800,  2'b0, 6'h3D},
    {4'd11, 20'd1030, 2'b0, 6'h3D},
    {4'd12, 20'd1600, 2'b0, 6'h3D},
    {4'd13, 20'd1030, 2'b0, 6'h3E},
    {4'd15, 20'd4100, 2'b0, 6'h3D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = {w, 2'b00}; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = {w, 2'b00};
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input logic run, input logic ien, input logic [3:0] sel,
                                      input logic [5:0] win, input logic ign);
    return {ign, 9'b0, win, 4'b0, sel, 6'b0, ien, run};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wdt_rst", {31'b0, wdt_rst}, 0);
    rd(2'd1, v); check("R1 ctl", v, 0);
    rd(2'd2, v); check("R1 status", v, 0);
    rd(2'd3, v); check("R1 count", v, 32'h3F);

    // R11 control readback and masking
    wr(2'd1, ctl(1'b0, 1'b1, 4'hA, 6'h2C, 1'b1));
    rd(2'd1, v); check("R11 ctl readback", v, 32'h802C_0A02);
    wr(2'd1, 32'hFFFF_FFFE);
    rd(2'd1, v); check("R11 ctl mask", v, 32'h803F_0F02);

    // R2 ratio table walk
    for (int i = 0; i < 12; i++) begin
      wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
      wr(2'd0, 32'h0000_5AA5);
      wr(2'd1, ctl(1'b1, 1'b0, VEC[i][31:28], 6'h3F, 1'b0));
      repeat (int'(VEC[i][27:8])) @(negedge clk);
      rd(2'd3, v);
      check($sformatf("R2 ratio code %0d", VEC[i][31:28]), v, {26'b0, VEC[i][5:0]});
    end

    // R3 stop holds the count
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
    rd(2'd3, v); check("R3 stopped", v, 32'h3D);
    repeat (50) @(negedge clk);
    rd(2'd3, v); check("R3 still stopped", v, 32'h3D);

    // R5 wrong key ignored
    wr(2'd0, 32'h0000_A55A);
    check("R5 no pulse", {31'b0, wdt_rst}, 0);
    rd(2'd3, v); check("R5 count kept", v, 32'h3D);
    rd(2'd2, v); check("R5 status kept", v, 0);

    // R6 early refresh
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h10, 1'b0));
    wr(2'd0, 32'h0000_5AA5);
    check("R6 pulse high", {31'b0, wdt_rst}, 1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, wdt_rst}, 0);
    rd(2'd2, v); check("R6 reset flag", v, 32'h2);
    rd(2'd3, v); check("R6 reloaded", v, 32'h3F);
    wr(2'd2, 32'h2);
    rd(2'd2, v); check("R9 clear reset flag", v, 0);

    // R8 window match, irq gating; R4 valid refresh
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h30, 1'b0));
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R8 match flag", v, 32'h1);
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(2'd0, 32'h0000_5AA5);
    check("R4 no pulse", {31'b0, wdt_rst}, 0);
    rd(2'd3, v); check("R4 reload", v, 32'h3F);
    rd(2'd2, v); check("R4 no reset flag", v, 32'h1);
    wr(2'd1, ctl(1'b1, 1'b1, 4'd0, 6'h30, 1'b0));
    check("R8 irq on", {31'b0, irq}, 1);
    wr(2'd2, 32'h1);
    check("R9 irq cleared", {31'b0, irq}, 0);

    // R12 refresh on the timeout edge
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
    wr(2'd0, 32'h0000_5AA5);
    wr(2'd2, 32'h3);
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h3F, 1'b0));
    repeat (63) @(negedge clk);
    wr(2'd0, 32'h0000_5AA5);
    check("R12 no pulse", {31'b0, wdt_rst}, 0);
    rd(2'd3, v); check("R12 reloaded", v, 32'h3F);
    rd(2'd2, v); check("R12 no flag", v, 0);

    // R7 timeout
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
    wr(2'd0, 32'h0000_5AA5);
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h3F, 1'b0));
    first = 0;
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      if (wdt_rst && first == 0) first = n;
    end
    check("R7 timeout cycle", first, 64);
    rd(2'd2, v); check("R7 reset flag", v, 32'h2);

    // R10 debug hold
    wr(2'd2, 32'h2);
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
    wr(2'd0, 32'h0000_5AA5);
    dbg_halt = 1'b1;
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h3F, 1'b0));
    repeat (10) @(negedge clk);
    rd(2'd3, v); check("R10 held", v, 32'h3F);
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h3F, 1'b1));
    repeat (10) @(negedge clk);
    rd(2'd3, v); check("R10 halt ignored", v, 32'h35);
    dbg_halt = 1'b0;

    // R9 set beats clear in the same cycle
    wr(2'd1, ctl(1'b0, 1'b0, 4'd0, 6'h3F, 1'b0));
    wr(2'd0, 32'h0000_5AA5);
    wr(2'd2, 32'h3);
    wr(2'd1, ctl(1'b1, 1'b0, 4'd0, 6'h30, 1'b0));
    repeat (14) @(negedge clk);
    wr(2'd2, 32'h1);
    rd(2'd2, v); check("R9 set wins", v, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule